// File: doc/BRIEF.md
# Dual Page Buffer Commit Engine

The block keeps two 256-byte staging buffers. At any moment one of them is the host's buffer: loads and reads from the host land there, and a swap pulse hands the host the other one. A commit request names a destination address in the array and a count. The engine then reads the run out of the buffer that was the host's buffer when the commit was taken and streams it to the array's write port, one byte or one 16-bit word per accepted beat. Where the run starts in the buffer is not given separately. It is the low eight bits of the destination, so a buffer byte always lands at the array byte with the same offset inside its 256-byte segment.

The count comes as two bytes. The low byte holds the number of items minus one, so 00h moves a single item. The high byte must be zero. A commit whose high byte is nonzero, or whose run would pass the end of the 256-byte segment, is refused. The block then raises an error pulse and writes nothing.

While one buffer drains, the host may fill the other one and read it back. A load aimed at the buffer that is draining is held off by back-pressure. Stream rules: the load port (`ld_valid`/`ld_ready`), the commit port (`cm_valid`/`cm_ready`) and the array port (`arr_valid`/`arr_ready`) each transfer on a clock edge where both valid and ready are high. A source that has raised valid keeps it and its payload steady until the transfer happens. `arr_valid` never depends on `arr_ready`.

Top module: `pgbuf_commit`

## Requirements
- R1: After reset `busy`, `done`, `err` and `arr_valid` are low, `cm_ready` and `ld_ready` are high, and buffer 0 is the host's buffer.
- R2: A load in byte mode (`byte_mode`=1) writes `ld_data[7:0]` at offset `ld_off`. In word mode it writes word `ld_off[7:1]`, with the low byte of the word at the even offset. A read taken with `rd_en` returns the host's buffer on `rd_data` in the next cycle: `{8'h00, byte}` in byte mode, or `{odd byte, even byte}` in word mode.
- R3: A `swap` pulse flips which buffer is the host's buffer. The contents of both buffers are kept.
- R4: An accepted commit with low count byte C moves C+1 items. In byte mode the addresses run from `cm_dest` upward by 1 and `arr_byte`=1. In word mode the addresses start at `cm_dest` with bit 0 cleared and rise by 2, and `arr_byte`=0.
- R5: A commit whose high count byte is nonzero, or whose run crosses the segment, is refused. Crossing means offset+C > 255 in byte mode, or offset/2+C > 127 in word mode. A refused commit gives `err` high for exactly the next cycle and produces no array beat.
- R6: While `arr_valid` is high and `arr_ready` is low, address, data and `arr_byte` stay steady.
- R7: Each beat carries the buffer contents at the beat's address offset. In byte mode that is `{8'h00, byte}`. In word mode it is `{odd byte, even byte}`.
- R8: `busy` is high from the cycle after a commit is accepted until the last beat transfers. `done` is high for exactly the cycle after the last beat, and `busy` is already low in that cycle. `cm_ready` equals not `busy`.
- R9: During a commit, `ld_ready` is low while the host's buffer is the one draining. A held load is taken only after the drain and does not alter the streamed data.
- R10: A commit taken in the same cycle as a swap drains the buffer that was the host's before the swap. Loads to the other buffer are accepted during the drain and do not disturb the streamed data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1 = byte items, 0 = 16-bit word items (sampled per operation) |
| swap | input | 1 | Pulse: exchange host and spare buffer |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Load can be taken |
| ld_off | input | 8 | Byte offset in the host's buffer |
| ld_data | input | 16 | Load data |
| rd_en | input | 1 | Read request for the host's buffer |
| rd_off | input | 8 | Read byte offset |
| rd_data | output | 16 | Read result, one cycle after `rd_en` |
| cm_valid | input | 1 | Commit request |
| cm_ready | output | 1 | Commit can be taken |
| cm_dest | input | 16 | Array byte address of the first item |
| cm_cnt_lo | input | 8 | Items minus one |
| cm_cnt_hi | input | 8 | Upper count byte, must be zero |
| arr_valid | output | 1 | Array beat valid |
| arr_ready | input | 1 | Array accepts the beat |
| arr_addr | output | 16 | Array byte address of the beat |
| arr_data | output | 16 | Beat data |
| arr_byte | output | 1 | Beat is a single byte |
| busy | output | 1 | A commit is draining |
| done | output | 1 | One-cycle pulse after the final beat |
| err | output | 1 | One-cycle pulse after a refused commit |

## Verification
Two things can share one cycle. The first is the array draining one buffer while the host loads the other. The second is a commit being taken in the same cycle as a swap. The bench issues a commit with the swap pulse raised alongside it, then loads the new host buffer on every cycle of the drain while `arr_ready` stalls in a fixed pseudo-random pattern. Each streamed beat is compared with a bench model of the pre-swap buffer, and the new loads are read back afterwards. A second case holds a load to the draining buffer through a whole commit and checks that it is stalled, that it leaves the streamed data untouched, and that it is taken in the `done` cycle.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  typedef enum logic {
    ITEM_WORD = 1'b0,
    ITEM_BYTE = 1'b1
  } item_mode_e;
endpackage

// File: rtl/pbw_bank.sv
module pbw_bank
  import pbw_pkg::*;
#(
  parameter int unsigned NB = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   wr_sel,
  input  logic [$clog2(NB)-1:0]  wr_off,
  input  item_mode_e             wr_mode,
  input  logic [WORD_W-1:0]      wr_data,
  input  logic                   rd_en,
  input  logic                   rd_sel,
  input  logic [$clog2(NB)-1:0]  rd_off,
  input  item_mode_e             rd_mode,
  output logic [WORD_W-1:0]      rd_data,
  input  logic                   dr_sel,
  input  logic [$clog2(NB)-1:0]  dr_off,
  input  item_mode_e             dr_mode,
  output logic [WORD_W-1:0]      dr_data
);
  localparam int unsigned OFF_W = $clog2(NB);

  logic [BYTE_W-1:0] mem [2][NB];

  function automatic logic [WORD_W-1:0] fetch(input logic s, input logic [OFF_W-1:0] o,
                                              input item_mode_e m);
    logic [OFF_W-1:0] ev;
    ev = {o[OFF_W-1:1], 1'b0};
    if (m == ITEM_BYTE) return {{BYTE_W{1'b0}}, mem[s][o]};
    return {mem[s][ev | OFF_W'(1)], mem[s][ev]};
  endfunction

  logic [OFF_W-1:0] wr_ev;
  assign wr_ev = {wr_off[OFF_W-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_mode == ITEM_BYTE) begin
        mem[wr_sel][wr_off] <= wr_data[BYTE_W-1:0];
      end else begin
        mem[wr_sel][wr_ev]              <= wr_data[BYTE_W-1:0];
        mem[wr_sel][wr_ev | OFF_W'(1)]  <= wr_data[WORD_W-1:BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= fetch(rd_sel, rd_off, rd_mode);
  end

  assign dr_data = fetch(dr_sel, dr_off, dr_mode);
endmodule

// File: rtl/pbw_check.sv
module pbw_check #(
  parameter int unsigned NB = 256
) (
  input  logic [$clog2(NB)-1:0] off,
  input  logic [$clog2(NB)-1:0] cnt_lo,
  input  logic [$clog2(NB)-1:0] cnt_hi,
  input  logic                  byte_items,
  output logic                  ok
);
  localparam int unsigned OFF_W = $clog2(NB);
  localparam int unsigned SUM_W = OFF_W + 1;

  logic [SUM_W-1:0] end_b, end_w;
  logic fits;

  always_comb begin
    end_b = {1'b0, off} + {1'b0, cnt_lo};
    end_w = {2'b00, off[OFF_W-1:1]} + {1'b0, cnt_lo};
    fits  = byte_items ? (end_b < SUM_W'(NB)) : (end_w < SUM_W'(NB / 2));
    ok    = (cnt_hi == '0) && fits;
  end
endmodule

// File: rtl/pbw_drain.sv
module pbw_drain
  import pbw_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned NB = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  start_sel,
  input  logic [AW-1:0]         start_dest,
  input  logic [$clog2(NB)-1:0] start_cnt,
  input  item_mode_e            start_mode,
  input  logic                  arr_ready,
  output logic                  busy,
  output logic                  done,
  output logic                  sel,
  output logic [$clog2(NB)-1:0] off,
  output item_mode_e            mode,
  output logic                  arr_valid,
  output logic [AW-1:0]         arr_addr
);
  localparam int unsigned OFF_W = $clog2(NB);
  localparam int unsigned SEG_W = AW - OFF_W;

  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] left;
  logic             fire, last;

  assign fire      = busy && arr_ready;
  assign last      = (left == '0);
  assign arr_valid = busy;
  assign arr_addr  = {seg, off};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      sel  <= 1'b0;
      mode <= ITEM_WORD;
      seg  <= '0;
      off  <= '0;
      left <= '0;
    end else begin
      done <= fire && last;
      if (start) begin
        busy <= 1'b1;
        sel  <= start_sel;
        mode <= start_mode;
        seg  <= start_dest[AW-1:OFF_W];
        off  <= (start_mode == ITEM_BYTE) ? start_dest[OFF_W-1:0]
                                          : {start_dest[OFF_W-1:1], 1'b0};
        left <= start_cnt;
      end else if (fire) begin
        if (last) begin
          busy <= 1'b0;
        end else begin
          off  <= off + ((mode == ITEM_BYTE) ? OFF_W'(1) : OFF_W'(2));
          left <= left - OFF_W'(1);
        end
      end
    end
  end

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && !arr_ready) |=> (arr_valid && $stable(arr_addr) && $stable(mode)));

  a_r8_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> (done && !busy));

  a_r4_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last) |=> (off == OFF_W'($past(off) + (($past(mode) == ITEM_BYTE) ? 1 : 2))));
endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit
  import pbw_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned NB = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  byte_mode,
  input  logic                  swap,
  input  logic                  ld_valid,
  output logic                  ld_ready,
  input  logic [$clog2(NB)-1:0] ld_off,
  input  logic [15:0]           ld_data,
  input  logic                  rd_en,
  input  logic [$clog2(NB)-1:0] rd_off,
  output logic [15:0]           rd_data,
  input  logic                  cm_valid,
  output logic                  cm_ready,
  input  logic [AW-1:0]         cm_dest,
  input  logic [$clog2(NB)-1:0] cm_cnt_lo,
  input  logic [$clog2(NB)-1:0] cm_cnt_hi,
  output logic                  arr_valid,
  input  logic                  arr_ready,
  output logic [AW-1:0]         arr_addr,
  output logic [15:0]           arr_data,
  output logic                  arr_byte,
  output logic                  busy,
  output logic                  done,
  output logic                  err
);
  localparam int unsigned OFF_W = $clog2(NB);

  item_mode_e       cur_mode, dr_mode;
  logic             host_sel, dr_sel, fits_ok, cm_take, ld_take;
  logic [OFF_W-1:0] dr_off;

  assign cur_mode = byte_mode ? ITEM_BYTE : ITEM_WORD;
  assign cm_ready = !busy;
  assign cm_take  = cm_valid && cm_ready;
  assign ld_ready = !(busy && (dr_sel == host_sel));
  assign ld_take  = ld_valid && ld_ready;
  assign arr_byte = (dr_mode == ITEM_BYTE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_sel <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (swap) host_sel <= !host_sel;
      err <= cm_take && !fits_ok;
    end
  end

  pbw_check #(.NB(NB)) u_check (
    .off        (cm_dest[OFF_W-1:0]),
    .cnt_lo     (cm_cnt_lo),
    .cnt_hi     (cm_cnt_hi),
    .byte_items (byte_mode),
    .ok         (fits_ok)
  );

  pbw_drain #(.AW(AW), .NB(NB)) u_drain (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (cm_take && fits_ok),
    .start_sel  (host_sel),
    .start_dest (cm_dest),
    .start_cnt  (cm_cnt_lo),
    .start_mode (cur_mode),
    .arr_ready  (arr_ready),
    .busy       (busy),
    .done       (done),
    .sel        (dr_sel),
    .off        (dr_off),
    .mode       (dr_mode),
    .arr_valid  (arr_valid),
    .arr_addr   (arr_addr)
  );

  pbw_bank #(.NB(NB)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ld_take),
    .wr_sel  (host_sel),
    .wr_off  (ld_off),
    .wr_mode (cur_mode),
    .wr_data (ld_data),
    .rd_en   (rd_en),
    .rd_sel  (host_sel),
    .rd_off  (rd_off),
    .rd_mode (cur_mode),
    .rd_data (rd_data),
    .dr_sel  (dr_sel),
    .dr_off  (dr_off),
    .dr_mode (dr_mode),
    .dr_data (arr_data)
  );

  a_r5_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !arr_valid));

  a_r9_no_load_into_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_take && busy) |-> (host_sel != dr_sel));

  a_r8_done_err_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));

  a_r10_swap_keeps_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && swap) |=> (busy ? $stable(dr_sel) : 1'b1));
endmodule

// File: tb/sim_pgbuf_commit.sv
module sim_pgbuf_commit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_mode = 1'b1, swap = 1'b0, ld_valid = 1'b0, rd_en = 1'b0;
  logic        cm_valid = 1'b0, arr_ready = 1'b0;
  logic [7:0]  ld_off = '0, rd_off = '0, cm_cnt_lo = '0, cm_cnt_hi = '0;
  logic [15:0] ld_data = '0, cm_dest = '0;
  logic        ld_ready, cm_ready, arr_valid, arr_byte, busy, done, err;
  logic [15:0] rd_data, arr_addr, arr_data;

  int nvec = 0, nfail = 0, host = 0;
  logic [7:0] mdl [2][256];
  logic [7:0] lfsr = 8'h5B;

  always #4 clk = !clk;

  pgbuf_commit u0 (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .swap(swap),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_off(ld_off), .ld_data(ld_data),
    .rd_en(rd_en), .rd_off(rd_off), .rd_data(rd_data),
    .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_dest(cm_dest),
    .cm_cnt_lo(cm_cnt_lo), .cm_cnt_hi(cm_cnt_hi),
    .arr_valid(arr_valid), .arr_ready(arr_ready), .arr_addr(arr_addr),
    .arr_data(arr_data), .arr_byte(arr_byte),
    .busy(busy), .done(done), .err(err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void mdl_write(input int s, input bit bm, input int o, input logic [15:0] d);
    if (bm) mdl[s][o] = d[7:0];
    else begin
      mdl[s][o & 254]       = d[7:0];
      mdl[s][(o & 254) + 1] = d[15:8];
    end
  endfunction

  function automatic logic [15:0] mdl_get(input int s, input bit bm, input int o);
    if (bm) return {8'h00, mdl[s][o]};
    return {mdl[s][(o & 254) + 1], mdl[s][o & 254]};
  endfunction

  task automatic do_load(input bit bm, input int o, input logic [15:0] d);
    byte_mode = bm; ld_valid = 1'b1; ld_off = 8'(o); ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
    mdl_write(host, bm, o, d);
  endtask

  task automatic do_read(input bit bm, input int o, input string req);
    logic [15:0] e;
    byte_mode = bm; rd_en = 1'b1; rd_off = 8'(o);
    @(negedge clk);
    rd_en = 1'b0;
    e = mdl_get(host, bm, o);
    check(rd_data == e, req, rd_data, e);
  endtask

  task automatic do_swap();
    swap = 1'b1;
    @(negedge clk);
    swap = 1'b0;
    host ^= 1;
  endtask

  // side: 0 none, 1 load the other buffer every cycle (R10), 2 hold a load to the draining buffer (R9)
  task automatic do_commit(input bit bm, input int dest, input int lo, input int hi,
                           input bit with_swap, input int side);
    int src, o, n, i, step, po;
    bit exp_err, rdy, pend;
    logic [15:0] ea, ed, pd;
    src = host;
    o = dest & 255;
    exp_err = (hi != 0) || (bm ? (o + lo > 255) : ((o >> 1) + lo > 127));
    check(cm_ready == 1'b1, "R8 cm_ready idle", cm_ready, 1);
    byte_mode = bm; cm_valid = 1'b1; cm_dest = 16'(dest);
    cm_cnt_lo = 8'(lo); cm_cnt_hi = 8'(hi); swap = with_swap;
    @(negedge clk);
    cm_valid = 1'b0; swap = 1'b0;
    if (with_swap) host ^= 1;
    if (exp_err) begin
      check(err && !busy && !arr_valid, "R5 refused commit", {err, busy, arr_valid}, 3'b100);
      @(negedge clk);
      check(!err && !arr_valid, "R5 err one cycle", {err, arr_valid}, 0);
      return;
    end
    check(!err, "R5 no err on legal commit", err, 0);
    n = lo + 1;
    step = bm ? 1 : 2;
    po = o & (bm ? 255 : 254);
    i = 0;
    if (side == 2) begin
      ld_valid = 1'b1; ld_off = 8'(po); ld_data = 16'hC3A5;
    end
    while (i < n) begin
      ea = {dest[15:8], 8'(po + step * i)};
      ed = mdl_get(src, bm, po + step * i);
      check(arr_valid && busy, "R8 busy during drain", {arr_valid, busy}, 3);
      check(arr_addr == ea, bm ? "R4 byte address" : "R4 word address", arr_addr, ea);
      check(arr_data == ed, "R7 beat data", arr_data, ed);
      check(arr_byte == bm, "R4 arr_byte", arr_byte, bm);
      if (side == 2) check(ld_ready == 1'b0, "R9 load to draining buffer stalled", ld_ready, 0);
      rdy = lfsr[0] | lfsr[1];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      arr_ready = rdy;
      pend = 1'b0;
      if (side == 1) begin
        check(ld_ready == 1'b1, "R10 load other buffer accepted", ld_ready, 1);
        ld_valid = 1'b1; ld_off = 8'((i * 7 + 3) & 255); pd = 16'(i * 29 + 17);
        ld_data = pd; pend = 1'b1;
      end
      @(negedge clk);
      arr_ready = 1'b0;
      if (pend) begin
        ld_valid = 1'b0;
        mdl_write(host, bm, (i * 7 + 3) & 255, pd);
      end
      if (rdy) i++;
    end
    check(done && !busy && !arr_valid, "R8 done pulse after last", {done, busy, arr_valid}, 3'b100);
    check(cm_ready == 1'b1, "R8 cm_ready after drain", cm_ready, 1);
    if (side == 2) begin
      check(ld_ready == 1'b1, "R9 held load released", ld_ready, 1);
      @(negedge clk);
      ld_valid = 1'b0;
      mdl_write(host, bm, po, 16'hC3A5);
    end else begin
      @(negedge clk);
    end
    check(!done, "R8 done one cycle", done, 0);
  endtask

  initial begin
    #(8 * 190000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int boffs[7] = '{0, 1, 37, 128, 200, 254, 255};
    int bcnts[7] = '{0, 1, 17, 54, 127, 200, 255};
    int woffs[6] = '{0, 2, 3, 126, 200, 254};
    int wcnts[6] = '{0, 5, 27, 64, 127, 128};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !err && !arr_valid, "R1 reset outputs", {busy, done, err, arr_valid}, 0);
    check(cm_ready && ld_ready, "R1 reset readies", {cm_ready, ld_ready}, 3);

    // R2 fill buffer 0 in byte mode, buffer 1 in word mode
    for (int x = 0; x < 256; x++) do_load(1'b1, x, 16'((x * 37 + 5) & 255));
    do_swap();
    for (int x = 0; x < 128; x++) do_load(1'b0, 2 * x, 16'((x * 1103 + 71) & 16'hFFFF));
    for (int x = 0; x < 256; x += 17) do_read(1'b1, x, "R2 byte read buf1");
    for (int x = 1; x < 256; x += 23) do_read(1'b0, x, "R2 word read buf1");
    // R3 swap back: buffer 0 kept
    do_swap();
    for (int x = 3; x < 256; x += 19) do_read(1'b1, x, "R3 buf0 kept after swaps");
    for (int x = 0; x < 256; x += 31) do_read(1'b0, x, "R3 word view buf0");

    // R4 R5 R7 byte-mode sweep
    foreach (boffs[a]) foreach (bcnts[b])
      do_commit(1'b1, 16'h3A00 + boffs[a], bcnts[b], 0, 1'b0, 0);
    // R4 R5 R7 word-mode sweep on buffer 1
    do_swap();
    foreach (woffs[a]) foreach (wcnts[b])
      do_commit(1'b0, 16'hC100 + woffs[a], wcnts[b], 0, 1'b0, 0);
    // R5 nonzero upper count byte
    do_commit(1'b1, 16'h0010, 0, 1, 1'b0, 0);
    do_commit(1'b0, 16'h0000, 3, 8'h80, 1'b0, 0);

    // R10 commit with swap in same cycle, loads to other buffer during drain
    do_commit(1'b1, 16'h7720, 90, 0, 1'b1, 1);
    for (int x = 3; x < 256; x += 7) do_read(1'b1, x, "R10 loads during drain");
    do_commit(1'b0, 16'h5504, 40, 0, 1'b1, 1);
    for (int x = 3; x < 256; x += 14) do_read(1'b0, x, "R10 word loads during drain");

    // R9 held load against draining buffer
    do_commit(1'b1, 16'h1240, 60, 0, 1'b0, 2);
    do_read(1'b1, 8'h40, "R9 held load landed");
    do_commit(1'b0, 16'h2286, 20, 0, 1'b0, 2);
    do_read(1'b0, 8'h86, "R9 held word load landed");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule